// File: doc/BRIEF.md
# Bit-Clock Edge Recovery

This block takes a bit clock that arrives from off chip, with no known phase relation to the local fast clock, and turns it into a clean filtered level plus a one-cycle edge strobe that downstream framing logic can use. The raw input is first passed through a two-stage synchronizer. A level change is then accepted only after the synchronized input has shown the new value for a programmed number of consecutive fast-clock samples. Short glitches are rejected this way.

After a change is confirmed, the strobe is placed in time by a programmable signed trim. The full shift from the raw change to the strobe is the filter length, plus the synchronizer depth, plus one cycle, plus the trim. When that shift is shorter than the time confirmation already took, the strobe is issued at once. Strobes still waiting for their placement are held in a small ordered queue. This lets a long trim span several bit-clock edges.

Top module: `bitclk_edge_recover`

## Requirements
- R1: The raw input is sampled by a two-stage synchronizer, so the synchronized level trails `bclk_in` by exactly two fast-clock cycles.
- R2: Call edge 0 the first rising edge of `clk` that samples a new `bclk_in` value, and let Neff be `samp_count`, or 1 when `samp_count` is 0. If the new value is then held, `bclk_level` takes it in the cycle after edge Neff+1 and not before.
- R3: Every synchronized sample that equals the current filtered level clears the run count. A pulse shorter than Neff cycles changes neither `bclk_level` nor `edge_stb`, and a run broken by one sample of the old level must be counted again from zero.
- R4: For a confirmed change, `edge_stb` is high for exactly the one cycle after edge max(Neff+1, `samp_count`+2+`samp_delta`). Here `samp_delta` is a signed two's-complement value. This equals a total shift of `samp_count`+3+`samp_delta` cycles measured from the edge before edge 0.
- R5: When `samp_count`+2+`samp_delta` is at most Neff+1, the shift is clamped. The strobe then appears in the same cycle as the change of `bclk_level`.
- R6: While `edge_stb` is high, `edge_rise` is 1 for a change from 0 to 1 and 0 for a change from 1 to 0.
- R7: Strobes come out in the order their changes were confirmed, one per change. At most PEND_DEPTH (default 4) delayed strobes can wait at once. A change confirmed while that many are waiting still updates `bclk_level` but gives no strobe.
- R8: While `rst` is high, `bclk_level` and `edge_stb` are 0 and every waiting strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Raw external bit clock, asynchronous |
| samp_count | input | CNT_W (16) | Consecutive samples needed to accept a level change |
| samp_delta | input | CNT_W (16) | Signed trim of the strobe position, in fast-clock cycles |
| bclk_level | output | 1 | Filtered bit-clock level |
| edge_stb | output | 1 | One-cycle strobe marking the placed edge |
| edge_rise | output | 1 | Direction of the strobed edge, 1 = rising |

## Verification
Clean held steps are applied with a mid-size filter and a zero trim, with a negative trim large enough to force the clamp, and with a zero filter length. These tell apart the placed strobe, the immediate strobe and the treatment of a count of 0 as 1. A pulse one sample too short, and a run broken by a single sample of the old level, separate a correct restarting count from one that accumulates or ignores reversions. Two edges under a long positive trim show that direction and order survive queuing. A burst of six quick toggles under a still longer trim shows that only the first four make strobes while the level still follows all six.

// File: rtl/bce_pkg.sv
package bce_pkg;
  typedef enum logic {
    DIR_FALL = 1'b0,
    DIR_RISE = 1'b1
  } edge_dir_e;
endpackage

// File: rtl/bce_sync.sv
module bce_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bce_filter.sv
module bce_filter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [CNT_W-1:0] n_cfg,
  output logic             level,
  output logic             confirm,
  output logic             new_val
);
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] n_eff;
  logic [CNT_W:0]   run_next;
  logic             differ;

  // a count of zero behaves as a count of one
  assign n_eff    = (n_cfg == '0) ? CNT_W'(1) : n_cfg;
  assign differ   = (din != level);
  assign run_next = {1'b0, run_cnt} + (CNT_W+1)'(1);
  assign confirm  = differ && (run_next >= {1'b0, n_eff});
  assign new_val  = din;

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= 1'b0;
      run_cnt <= '0;
    end else if (confirm) begin
      level   <= din;
      run_cnt <= '0;
    end else if (differ) begin
      run_cnt <= run_next[CNT_W-1:0];
    end else begin
      run_cnt <= '0;   // any reversion restarts the run
    end
  end
endmodule

// File: rtl/bce_place.sv
module bce_place
  import bce_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STAGES = 2,
  parameter int DEPTH  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             confirm,
  input  logic             new_val,
  input  logic [CNT_W-1:0] n_cfg,
  input  logic [CNT_W-1:0] delta_cfg,
  output logic             stb,
  output logic             stb_rise
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TS_W = CNT_W + 1;
  localparam int EW   = CNT_W + 3;
  localparam logic signed [EW-1:0] ONE   = EW'(1);
  localparam logic signed [EW-1:0] ZERO  = '0;
  localparam logic signed [EW-1:0] SYNCS = EW'(STAGES);

  logic [CNT_W-1:0]     n_eff;
  logic signed [EW-1:0] total_s;
  logic signed [EW-1:0] spent_s;
  logic signed [EW-1:0] wait_s;
  logic                 wait_zero;
  logic [TS_W-1:0]      wait_u;

  logic [TS_W-1:0]      now_ts;
  logic [TS_W:0]        pend_mem [DEPTH];
  logic [AW:0]          wptr;
  logic [AW:0]          rptr;
  logic                 empty;
  logic                 full;
  logic [TS_W:0]        head;
  logic                 pop;
  logic                 push;
  logic                 now_hit;
  edge_dir_e            dir_in;

  // remaining wait = (N + sync + 1 + delta) - (Neff + sync), clamped at zero
  assign n_eff     = (n_cfg == '0) ? CNT_W'(1) : n_cfg;
  assign total_s   = $signed({3'b000, n_cfg}) + SYNCS + ONE
                   + $signed({{3{delta_cfg[CNT_W-1]}}, delta_cfg});
  assign spent_s   = $signed({3'b000, n_eff}) + SYNCS;
  assign wait_s    = total_s - spent_s;
  assign wait_zero = (wait_s <= ZERO);
  assign wait_u    = wait_zero ? '0 : wait_s[TS_W-1:0];

  assign dir_in  = edge_dir_e'(new_val);
  assign empty   = (wptr == rptr);
  assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign head    = pend_mem[rptr[AW-1:0]];
  assign now_hit = (head[TS_W-1:0] == now_ts);
  assign pop     = !empty && now_hit;
  assign push    = confirm && !wait_zero && !full;

  // storage without reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (push) pend_mem[wptr[AW-1:0]] <= {dir_in, now_ts + wait_u};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now_ts   <= '0;
      wptr     <= '0;
      rptr     <= '0;
      stb      <= 1'b0;
      stb_rise <= 1'b0;
    end else begin
      now_ts <= now_ts + TS_W'(1);
      if (push) wptr <= wptr + (AW+1)'(1);
      if (pop)  rptr <= rptr + (AW+1)'(1);
      if (confirm && wait_zero) begin
        stb      <= 1'b1;
        stb_rise <= new_val;
      end else if (pop) begin
        stb      <= 1'b1;
        stb_rise <= head[TS_W];
      end else begin
        stb      <= 1'b0;
        stb_rise <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bitclk_edge_recover.sv
module bitclk_edge_recover #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PEND_DEPTH  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_in,
  input  logic [CNT_W-1:0] samp_count,
  input  logic [CNT_W-1:0] samp_delta,
  output logic             bclk_level,
  output logic             edge_stb,
  output logic             edge_rise
);
  logic sync_q;
  logic confirm;
  logic new_val;

  bce_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (bclk_in),
    .q   (sync_q)
  );

  bce_filter #(.CNT_W(CNT_W)) u_filter (
    .clk     (clk),
    .rst     (rst),
    .din     (sync_q),
    .n_cfg   (samp_count),
    .level   (bclk_level),
    .confirm (confirm),
    .new_val (new_val)
  );

  bce_place #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES), .DEPTH(PEND_DEPTH)) u_place (
    .clk       (clk),
    .rst       (rst),
    .confirm   (confirm),
    .new_val   (new_val),
    .n_cfg     (samp_count),
    .delta_cfg (samp_delta),
    .stb       (edge_stb),
    .stb_rise  (edge_rise)
  );
endmodule

// File: rtl/bitclk_edge_recover_chk.sv
module bitclk_edge_recover_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic bclk_in,
  input logic sync_q,
  input logic bclk_level,
  input logic edge_stb
);
  logic [1:0]  age;
  logic        lvl_prev;
  logic [31:0] chg_cnt;
  logic [31:0] stb_cnt;
  logic [31:0] chg_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      age      <= '0;
      lvl_prev <= 1'b0;
      chg_cnt  <= '0;
      stb_cnt  <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      lvl_prev <= bclk_level;
      if (bclk_level != lvl_prev) chg_cnt <= chg_cnt + 32'd1;
      if (edge_stb) stb_cnt <= stb_cnt + 32'd1;
    end
  end

  assign chg_now = chg_cnt + ((bclk_level != lvl_prev) ? 32'd1 : 32'd0);

  generate
    if (SYNC_STAGES == 2) begin : g_lag
      assert_sync_lag_R1: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (sync_q == $past(bclk_in, 2)));
    end
  endgenerate

  assert_level_from_sync_R2: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && bclk_level != $past(bclk_level)) |-> (bclk_level == $past(sync_q)));

  assert_hold_on_match_R3: assert property (@(posedge clk) disable iff (rst)
    (sync_q == bclk_level) |=> $stable(bclk_level));

  assert_no_spurious_stb_R7: assert property (@(posedge clk) disable iff (rst)
    edge_stb |-> (chg_now > stb_cnt));
endmodule

bind bitclk_edge_recover bitclk_edge_recover_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bclk_in    (bclk_in),
  .sync_q     (sync_q),
  .bclk_level (bclk_level),
  .edge_stb   (edge_stb)
);

// File: tb/test_bitclk_edge_recover.sv
`timescale 1ns/1ps
module test_bitclk_edge_recover;
  typedef struct {
    int cyc;
    bit rise;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk_in = 1'b0;
  logic [15:0] samp_count = 16'd4;
  logic [15:0] samp_delta = 16'd0;
  logic        bclk_level;
  logic        edge_stb;
  logic        edge_rise;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitclk_edge_recover i_bitclk_edge_recover (
    .clk        (clk),
    .rst        (rst),
    .bclk_in    (bclk_in),
    .samp_count (samp_count),
    .samp_delta (samp_delta),
    .bclk_level (bclk_level),
    .edge_stb   (edge_stb),
    .edge_rise  (edge_rise)
  );

  function automatic int exp_x(int n, int d);
    int neff = (n == 0) ? 1 : n;
    int a = neff + 1;
    int b = n + 2 + d;
    return (a > b) ? a : b;
  endfunction

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_cfg(int n, int d);
    samp_count = 16'(n);
    samp_delta = 16'(d);
  endtask

  // driver: change the raw input now and push the expected strobe
  task automatic drive(bit v, bit expect_stb);
    exp_t e;
    bclk_in = v;
    if (expect_stb) begin
      e.cyc  = cyc + 1 + exp_x(int'(samp_count), int'($signed(samp_delta)));
      e.rise = v;
      sb.push_back(e);
    end
  endtask

  task automatic chk_level(bit exp, string req);
    checks++;
    if (bclk_level !== exp) begin
      failures++;
      $display("FAIL %s level at cycle %0d: got %0b expected %0b", req, cyc, bclk_level, exp);
    end
  endtask

  // monitor: compare strobes against the scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (edge_stb) begin
        checks++;
        if (sb.size() == 0) begin
          failures++;
          $display("FAIL R3/R7 unexpected strobe at cycle %0d: got 1 expected 0", cyc);
        end else if (sb[0].cyc != cyc) begin
          failures++;
          $display("FAIL R4 strobe at cycle %0d: got cycle %0d expected cycle %0d", cyc, cyc, sb[0].cyc);
          if (sb[0].cyc < cyc) void'(sb.pop_front());
        end else begin
          if (edge_rise !== sb[0].rise) begin
            failures++;
            $display("FAIL R6 direction at cycle %0d: got %0b expected %0b", cyc, edge_rise, sb[0].rise);
          end
          void'(sb.pop_front());
        end
      end
      while (sb.size() > 0 && sb[0].cyc < cyc) begin
        checks++;
        failures++;
        $display("FAIL R4/R5 missing strobe: got none by cycle %0d expected cycle %0d", cyc, sb[0].cyc);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired at cycle %0d: got hang expected finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int k;
    tick(4);
    // R8: reset state
    checks++;
    if (bclk_level !== 1'b0 || edge_stb !== 1'b0) begin
      failures++;
      $display("FAIL R8 reset outputs: got %0b%0b expected 00", bclk_level, edge_stb);
    end
    rst = 1'b0;
    tick(4);
    chk_level(1'b0, "R8");

    // R2/R4: N=4, delta=0, rising step
    set_cfg(4, 0);
    tick(2);
    k = cyc;
    drive(1'b1, 1'b1);
    tick(5); chk_level(1'b0, "R2");
    tick(1); chk_level(1'b1, "R2");
    tick(20);

    // R3: three-sample glitch with N=4 is ignored
    drive(1'b0, 1'b0);
    tick(3);
    drive(1'b1, 1'b0);
    tick(4); chk_level(1'b1, "R3");
    tick(20); chk_level(1'b1, "R3");

    // R3: run broken by one sample restarts counting
    drive(1'b0, 1'b0);
    tick(3);
    drive(1'b1, 1'b0);
    tick(1);
    drive(1'b0, 1'b1);
    tick(5); chk_level(1'b1, "R3");
    tick(1); chk_level(1'b0, "R3");
    tick(20);

    // R5: clamp, strobe coincides with level change
    set_cfg(3, -10);
    tick(2);
    drive(1'b1, 1'b1);
    tick(4); chk_level(1'b0, "R5");
    tick(1); chk_level(1'b1, "R5");
    tick(20);

    // R2: count of zero acts as one
    set_cfg(0, 0);
    tick(2);
    drive(1'b0, 1'b1);
    tick(2); chk_level(1'b1, "R2");
    tick(1); chk_level(1'b0, "R2");
    tick(20);

    // R6/R7: two edges pending under a long trim
    set_cfg(2, 20);
    tick(2);
    drive(1'b1, 1'b1);
    tick(6);
    drive(1'b0, 1'b1);
    tick(60);
    chk_level(1'b0, "R7");

    // R7: queue overflow drops the newest strobes
    set_cfg(1, 40);
    tick(2);
    for (int i = 0; i < 6; i++) begin
      drive(((i % 2) == 0) ? 1'b1 : 1'b0, (i < 4) ? 1'b1 : 1'b0);
      tick(3);
    end
    chk_level(1'b0, "R7");
    tick(100);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R7 pending strobes at end: got %0d expected 0", sb.size());
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule